// File: doc/BRIEF.md
# Boot-Sector Program/Erase Gatekeeper

This block sits between a command decoder and a parallel NOR flash array of eleven independently erasable sectors (1 MB total). It turns each presented address into a sector number and decides whether a requested program or erase may begin. The address is a 16-bit word address in word mode or a byte address in byte mode. The sectors are one 16 KB boot sector, two 8 KB parameter sectors, one 96 KB main sector and seven 128 KB main sectors. A parameter places the small sectors either at the low end (bottom layout) or at the high end (top layout) of the address space.

The boot sector is guarded. A request aimed at it starts only when either the high-voltage unlock input or the write-protect-release input is high, and one of them must stay high until the array reports completion. The other sectors need neither input. A refused or aborted operation raises a sticky error flag in a small status byte. The status byte also carries a ready bit and a supply-fault flag. A power-down input clears this state and returns the read path to array reads. The busy period is modelled by a start pulse towards the array and a done pulse back from it.

Top module: `flash_sector_guard`

## Requirements
- R1: With the bottom layout, `sector_idx` one clock after a word address w is presented is 0 for w below 2000h, 1 for 2000h–2FFFh, 2 for 3000h–3FFFh, 3 for 4000h–FFFFh, and 3 + w/10000h from 10000h up to 7FFFFh.
- R2: With the top layout, `sector_idx` is w/10000h for w below 70000h, 7 for 70000h–7BFFFh, 8 for 7C000h–7CFFFh, 9 for 7D000h–7DFFFh and 10 (the boot sector) for 7E000h–7FFFFh.
- R3: With `byte_mode` high, the sector is the one for word address `addr` >> 1. With `byte_mode` low, `addr[19]` has no effect and bits 18:0 are the word address.
- R4: A request to a non-boot sector with `vpp_ok` high, while not busy, gives a one-cycle `op_start` and raises `busy` on the next clock edge, whatever the unlock inputs are. The ready bit (`status[7]`) then reads 0.
- R5: A boot-sector request with both `unlock_hv` and `wp_hi` low is refused: no `op_start`, `busy` stays low, and `status[4]` (program error) or `status[5]` (erase error) is set according to `req_erase`.
- R6: A boot-sector request is accepted when `unlock_hv` or `wp_hi` is high.
- R7: If both unlock inputs are low during a busy boot-sector operation, the next edge pulses `op_abort`, clears `busy` and sets the matching error flag. A non-boot operation ignores the unlock inputs.
- R8: `op_done` during busy clears `busy` on the next edge and the ready bit returns to 1.
- R9: A request while `vpp_ok` is low is refused and sets `status[3]` (supply fault) as well as the matching program or erase error flag.
- R10: Error flags are sticky. New requests are accepted while they are set. `clr_status` clears them, and a flag being set in the same cycle as a clear stays set.
- R11: `pd_n` low clears all flags, `busy` and `read_status_sel` on the next edge. Requests made while it is low are ignored.
- R12: `rd_status_req` sets `read_status_sel` and `rd_array_req` clears it.
- R13: A request presented while `busy` is high is ignored: no flag changes and the running operation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low; clears state synchronously |
| byte_mode | input | 1 | 1: addr is a byte address; 0: addr[18:0] is a word address |
| addr | input | 20 | Access address |
| req_valid | input | 1 | One-cycle program/erase request |
| req_erase | input | 1 | 1 erase, 0 program |
| unlock_hv | input | 1 | High-voltage unlock present |
| wp_hi | input | 1 | Write-protect released |
| vpp_ok | input | 1 | Programming supply within range |
| op_done | input | 1 | Array reports the operation finished |
| clr_status | input | 1 | Clear error flags |
| rd_status_req | input | 1 | Switch read path to status |
| rd_array_req | input | 1 | Switch read path to array |
| sector_idx | output | 4 | Registered sector number, lowest address first |
| op_start | output | 1 | One-cycle start pulse to the array |
| op_abort | output | 1 | One-cycle abort pulse to the array |
| busy | output | 1 | Operation in progress |
| status | output | 8 | bit7 ready, bit5 erase error, bit4 program error, bit3 supply fault |
| read_status_sel | output | 1 | 1 while the read path shows the status byte |

## Verification
The bench builds two copies of the default 19-bit word geometry side by side, one with the bottom layout and one with the top layout, and drives both from the same inputs. Because every sector edge is a multiple of 1000h words, sweeping both ends of each 800h-word slice in word mode, and of each 1000h-byte slice in byte mode, covers every boundary in both layouts. This happens with `addr[19]` toggled in word mode. With both copies running, one request can land on the boot sector of one copy and on a main sector of the other, so refusal and acceptance can be compared in the same cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // status byte bit positions
  localparam int unsigned ST_READY  = 7;
  localparam int unsigned ST_ERASE  = 5;
  localparam int unsigned ST_WRITE  = 4;
  localparam int unsigned ST_SUPPLY = 3;

  typedef enum logic {KIND_PROGRAM = 1'b0, KIND_ERASE = 1'b1} op_kind_e;

  typedef struct packed {
    logic erase_err;
    logic write_err;
    logic supply_err;
  } err_flags_t;
endpackage

// File: rtl/fsg_sector_decode.sv
module fsg_sector_decode #(
  parameter bit TOP_BOOT = 1'b0,
  parameter int WORD_AW  = 19,
  parameter int MAIN_LG  = 16,
  parameter int BOOT_LG  = 13,
  parameter int PARAM_LG = 12,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_mode,
  input  logic [WORD_AW:0]   addr,
  output logic [IDX_W-1:0]   idx_now,
  output logic               is_boot_now,
  output logic [IDX_W-1:0]   idx_q
);
  localparam int HW   = WORD_AW - MAIN_LG;
  localparam int NSEC = (1 << HW) + 3;
  localparam logic [MAIN_LG-1:0] EDGE_PAR0 = MAIN_LG'(1 << BOOT_LG);
  localparam logic [MAIN_LG-1:0] EDGE_PAR1 = MAIN_LG'((1 << BOOT_LG) + (1 << PARAM_LG));
  localparam logic [MAIN_LG-1:0] EDGE_MAIN = MAIN_LG'((1 << BOOT_LG) + 2 * (1 << PARAM_LG));
  localparam logic [IDX_W-1:0]   LAST_IDX  = IDX_W'(NSEC - 1);

  // sector number when the small sectors sit at the low end of the space
  function automatic logic [IDX_W-1:0] low_side_index(input logic [WORD_AW-1:0] w);
    logic [HW-1:0]      hi;
    logic [MAIN_LG-1:0] lo;
    hi = w[WORD_AW-1:MAIN_LG];
    lo = w[MAIN_LG-1:0];
    if (hi != '0)            return IDX_W'(hi) + IDX_W'(3);
    else if (lo >= EDGE_MAIN) return IDX_W'(3);
    else if (lo >= EDGE_PAR1) return IDX_W'(2);
    else if (lo >= EDGE_PAR0) return IDX_W'(1);
    else                      return IDX_W'(0);
  endfunction

  logic [WORD_AW-1:0] word_w;
  assign word_w = byte_mode ? addr[WORD_AW:1] : addr[WORD_AW-1:0];

  generate
    if (TOP_BOOT) begin : g_top
      // mirrored layout: flip the address, then count from the far end
      assign idx_now     = LAST_IDX - low_side_index(~word_w);
      assign is_boot_now = (idx_now == LAST_IDX);
    end else begin : g_bottom
      assign idx_now     = low_side_index(word_w);
      assign is_boot_now = (idx_now == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_now;
  end

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic req_valid,
  input  logic req_erase,
  input  logic target_boot,
  input  logic unlock_any,
  input  logic vpp_ok,
  input  logic op_done,
  output logic busy,
  output logic op_start,
  output logic op_abort,
  output logic set_write_err,
  output logic set_erase_err,
  output logic set_supply_err
);
  logic     busy_q, boot_q, start_q, abort_q;
  op_kind_e kind_q;

  // named internal events
  logic ev_permit, ev_accept, ev_refuse, ev_abort, ev_finish;
  assign ev_permit = vpp_ok & (~target_boot | unlock_any);
  assign ev_accept = pd_n & req_valid & ~busy_q &  ev_permit;
  assign ev_refuse = pd_n & req_valid & ~busy_q & ~ev_permit;
  assign ev_abort  = pd_n & busy_q & boot_q & ~unlock_any;
  assign ev_finish = pd_n & busy_q & ~ev_abort & op_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      boot_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      kind_q  <= KIND_PROGRAM;
    end else if (!pd_n) begin
      busy_q  <= 1'b0;
      boot_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      kind_q  <= KIND_PROGRAM;
    end else begin
      start_q <= ev_accept;
      abort_q <= ev_abort;
      if (ev_accept) begin
        busy_q <= 1'b1;
        boot_q <= target_boot;
        kind_q <= req_erase ? KIND_ERASE : KIND_PROGRAM;
      end else if (ev_abort || ev_finish) begin
        busy_q <= 1'b0;
        boot_q <= 1'b0;
      end
    end
  end

  assign set_write_err  = (ev_refuse & ~req_erase) | (ev_abort & (kind_q == KIND_PROGRAM));
  assign set_erase_err  = (ev_refuse &  req_erase) | (ev_abort & (kind_q == KIND_ERASE));
  assign set_supply_err = ev_refuse & ~vpp_ok;

  assign busy     = busy_q;
  assign op_start = start_q;
  assign op_abort = abort_q;

  p_boot_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && boot_q) |-> $past(unlock_any));
  p_abort_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!busy_q && abort_q));
  p_hold_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pd_n && !op_done && !ev_abort) |=> busy_q);
  p_pd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!busy_q && !start_q));
endmodule

// File: rtl/fsg_status.sv
module fsg_status
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_n,
  input  logic       clr,
  input  logic       set_write,
  input  logic       set_erase,
  input  logic       set_supply,
  input  logic       ready,
  input  logic       rd_status_req,
  input  logic       rd_array_req,
  output logic [7:0] status_byte,
  output logic       read_status_sel
);
  err_flags_t flags_q;
  logic       rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rd_q    <= 1'b0;
    end else if (!pd_n) begin
      flags_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      // a set in the same cycle wins over a clear
      flags_q.write_err  <= set_write  | (flags_q.write_err  & ~clr);
      flags_q.erase_err  <= set_erase  | (flags_q.erase_err  & ~clr);
      flags_q.supply_err <= set_supply | (flags_q.supply_err & ~clr);
      if (rd_status_req)     rd_q <= 1'b1;
      else if (rd_array_req) rd_q <= 1'b0;
    end
  end

  always_comb begin
    status_byte            = '0;
    status_byte[ST_READY]  = ready;
    status_byte[ST_ERASE]  = flags_q.erase_err;
    status_byte[ST_WRITE]  = flags_q.write_err;
    status_byte[ST_SUPPLY] = flags_q.supply_err;
  end
  assign read_status_sel = rd_q;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.write_err && pd_n && !clr) |=> flags_q.write_err);
  p_pd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (flags_q == '0 && !rd_q));
endmodule

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
  parameter bit TOP_BOOT = 1'b0,
  parameter int WORD_AW  = 19,
  parameter int MAIN_LG  = 16,
  parameter int BOOT_LG  = 13,
  parameter int PARAM_LG = 12,
  localparam int NSEC    = (1 << (WORD_AW - MAIN_LG)) + 3,
  localparam int IDX_W   = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             byte_mode,
  input  logic [WORD_AW:0] addr,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic             unlock_hv,
  input  logic             wp_hi,
  input  logic             vpp_ok,
  input  logic             op_done,
  input  logic             clr_status,
  input  logic             rd_status_req,
  input  logic             rd_array_req,
  output logic [IDX_W-1:0] sector_idx,
  output logic             op_start,
  output logic             op_abort,
  output logic             busy,
  output logic [7:0]       status,
  output logic             read_status_sel
);
  logic [IDX_W-1:0] idx_now;
  logic             is_boot_now;
  logic             unlock_any;
  logic             set_wr, set_er, set_sup;

  assign unlock_any = unlock_hv | wp_hi;

  fsg_sector_decode #(
    .TOP_BOOT(TOP_BOOT), .WORD_AW(WORD_AW), .MAIN_LG(MAIN_LG),
    .BOOT_LG(BOOT_LG), .PARAM_LG(PARAM_LG), .IDX_W(IDX_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .addr(addr),
    .idx_now(idx_now), .is_boot_now(is_boot_now), .idx_q(sector_idx)
  );

  fsg_op_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .req_valid(req_valid), .req_erase(req_erase), .target_boot(is_boot_now),
    .unlock_any(unlock_any), .vpp_ok(vpp_ok), .op_done(op_done),
    .busy(busy), .op_start(op_start), .op_abort(op_abort),
    .set_write_err(set_wr), .set_erase_err(set_er), .set_supply_err(set_sup)
  );

  fsg_status u_status (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .clr(clr_status),
    .set_write(set_wr), .set_erase(set_er), .set_supply(set_sup),
    .ready(~busy), .rd_status_req(rd_status_req), .rd_array_req(rd_array_req),
    .status_byte(status), .read_status_sel(read_status_sel)
  );

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy);
  p_refused_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && req_valid && !busy && is_boot_now && !unlock_any) |=> !op_start);
endmodule

// File: tb/test_flash_sector_guard.sv
module test_flash_sector_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1, byte_mode = 1'b0;
  logic [19:0] addr = '0;
  logic        req_valid = 1'b0, req_erase = 1'b0, unlock_hv = 1'b0, wp_hi = 1'b0;
  logic        vpp_ok = 1'b1, op_done = 1'b0, clr_status = 1'b0;
  logic        rd_status_req = 1'b0, rd_array_req = 1'b0;

  logic [3:0] idx_b, idx_t;
  logic       start_b, start_t, abort_b, abort_t, busy_b, busy_t, rsel_b, rsel_t;
  logic [7:0] st_b, st_t;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  flash_sector_guard #(.TOP_BOOT(1'b0)) i_flash_sector_guard (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .byte_mode(byte_mode), .addr(addr),
    .req_valid(req_valid), .req_erase(req_erase), .unlock_hv(unlock_hv), .wp_hi(wp_hi),
    .vpp_ok(vpp_ok), .op_done(op_done), .clr_status(clr_status),
    .rd_status_req(rd_status_req), .rd_array_req(rd_array_req),
    .sector_idx(idx_b), .op_start(start_b), .op_abort(abort_b), .busy(busy_b),
    .status(st_b), .read_status_sel(rsel_b));

  flash_sector_guard #(.TOP_BOOT(1'b1)) i_flash_sector_guard_top (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .byte_mode(byte_mode), .addr(addr),
    .req_valid(req_valid), .req_erase(req_erase), .unlock_hv(unlock_hv), .wp_hi(wp_hi),
    .vpp_ok(vpp_ok), .op_done(op_done), .clr_status(clr_status),
    .rd_status_req(rd_status_req), .rd_array_req(rd_array_req),
    .sector_idx(idx_t), .op_start(start_t), .op_abort(abort_t), .busy(busy_t),
    .status(st_t), .read_status_sel(rsel_t));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // expected sector numbers from the requirement tables
  function automatic int ref_bottom(input int w);
    if (w < 'h2000)  return 0;
    if (w < 'h3000)  return 1;
    if (w < 'h4000)  return 2;
    if (w < 'h10000) return 3;
    return 3 + w / 'h10000;
  endfunction

  function automatic int ref_top(input int w);
    if (w >= 'h7E000) return 10;
    if (w >= 'h7D000) return 9;
    if (w >= 'h7C000) return 8;
    if (w >= 'h70000) return 7;
    return w / 'h10000;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic request(input int w, input logic erase);
    byte_mode = 1'b0; addr = 20'(w);
    req_valid = 1'b1; req_erase = erase;
    tick();
    req_valid = 1'b0; req_erase = 1'b0;
  endtask

  task automatic finish_op();
    op_done = 1'b1; tick(); op_done = 1'b0;
  endtask

  task automatic clear_flags();
    clr_status = 1'b1; tick(); clr_status = 1'b0;
  endtask

  task automatic probe_word(input int w, input logic b19);
    byte_mode = 1'b0; addr = {b19, 19'(w)};
    tick();
    chk("R1 bottom sector", 32'(idx_b), 32'(ref_bottom(w)));
    chk("R2 top sector", 32'(idx_t), 32'(ref_top(w)));
  endtask

  task automatic probe_byte(input int b);
    byte_mode = 1'b1; addr = 20'(b);
    tick();
    chk("R3 byte-mode bottom", 32'(idx_b), 32'(ref_bottom(b / 2)));
    chk("R3 byte-mode top", 32'(idx_t), 32'(ref_top(b / 2)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    chk("R8 reset status", 32'(st_b), 32'h80);
    chk("R4 reset busy", 32'(busy_b), 0);
    chk("R12 reset read select", 32'(rsel_b), 0);
    chk("R1 reset sector", 32'(idx_b), 0);

    // R1 R2 R3: sweep both ends of every slice, addr[19] toggled in word mode
    for (int s = 0; s < 256; s++) begin
      probe_word(s * 'h800, s[0]);
      probe_word(s * 'h800 + 'h7FF, ~s[0]);
    end
    for (int s = 0; s < 256; s++) begin
      probe_byte(s * 'h1000);
      probe_byte(s * 'h1000 + 'hFFF);
    end

    // R4: non-boot program, no unlock
    request('h20000, 1'b0);
    chk("R4 start pulse", 32'(start_b), 1);
    chk("R4 busy", 32'(busy_b), 1);
    chk("R4 ready low", 32'(st_b), 32'h00);
    tick();
    chk("R4 start is one cycle", 32'(start_b), 0);
    // R13: request while busy ignored
    request('h00000, 1'b0);
    chk("R13 no flag while busy", 32'(st_b), 32'h00);
    chk("R13 still busy", 32'(busy_b), 1);
    // R7: unlock irrelevant for non-boot op
    unlock_hv = 1'b1; tick(); unlock_hv = 1'b0; tick(); tick();
    chk("R7 non-boot ignores unlock", 32'(busy_b), 1);
    chk("R7 no abort non-boot", 32'(abort_b), 0);
    finish_op();
    chk("R8 done clears busy", 32'(busy_b), 0);
    chk("R8 ready back", 32'(st_b), 32'h80);

    // R5: boot program without unlock (bottom boot at 0; main on top layout)
    request('h00000, 1'b0);
    chk("R5 no start", 32'(start_b), 0);
    chk("R5 not busy", 32'(busy_b), 0);
    chk("R5 program error", 32'(st_b), 32'h90);
    chk("R5 top layout accepts word 0", 32'(start_t), 1);
    finish_op();
    // top boot address: top refuses, bottom accepts
    request('h7F000, 1'b1);
    chk("R5 top boot erase refused", 32'(st_t), 32'hA0);
    chk("R5 top not busy", 32'(busy_t), 0);
    chk("R4 bottom accepts 7F000", 32'(start_b), 1);
    finish_op();
    // R10: sticky, clear, erase error, accepted while set
    tick();
    chk("R10 sticky", 32'(st_b), 32'h90);
    clear_flags();
    chk("R10 clear", 32'(st_b), 32'h80);
    request('h01FFF, 1'b1);
    chk("R5 erase error", 32'(st_b), 32'hA0);
    request('h30000, 1'b0);
    chk("R10 accepted while flag set", 32'(start_b), 1);
    finish_op();
    chk("R10 flag kept through op", 32'(st_b), 32'hA0);
    clear_flags();
    clr_status = 1'b1;
    request('h00100, 1'b0);
    clr_status = 1'b0;
    chk("R10 set wins over clear", 32'(st_b), 32'h90);
    clear_flags();

    // R6: unlock_hv accepts boot erase
    unlock_hv = 1'b1;
    request('h00000, 1'b1);
    chk("R6 unlock_hv accept", 32'(start_b), 1);
    finish_op();
    unlock_hv = 1'b0;
    chk("R6 clean completion", 32'(st_b), 32'h80);
    // R6 wp_hi, then R7 drop it
    wp_hi = 1'b1;
    request('h01000, 1'b0);
    chk("R6 wp_hi accept", 32'(busy_b), 1);
    tick();
    wp_hi = 1'b0;
    tick();
    chk("R7 abort pulse", 32'(abort_b), 1);
    chk("R7 busy dropped", 32'(busy_b), 0);
    chk("R7 program error", 32'(st_b), 32'h90);
    clear_flags();

    // R9: supply fault
    vpp_ok = 1'b0;
    request('h40000, 1'b1);
    chk("R9 refused", 32'(busy_b), 0);
    chk("R9 supply and erase flag", 32'(st_b), 32'hA8);
    vpp_ok = 1'b1;
    clear_flags();

    // R12: read path select
    rd_status_req = 1'b1; tick(); rd_status_req = 1'b0;
    chk("R12 status read", 32'(rsel_b), 1);
    rd_array_req = 1'b1; tick(); rd_array_req = 1'b0;
    chk("R12 array read", 32'(rsel_b), 0);
    rd_status_req = 1'b1; tick(); rd_status_req = 1'b0;

    // R11: power-down clears everything
    request('h00000, 1'b0);
    request('h50000, 1'b0);
    chk("R11 precondition busy", 32'(busy_b), 1);
    pd_n = 1'b0;
    tick();
    chk("R11 status cleared", 32'(st_b), 32'h80);
    chk("R11 busy cleared", 32'(busy_b), 0);
    chk("R11 read path array", 32'(rsel_b), 0);
    request('h50000, 1'b0);
    chk("R11 request ignored", 32'(start_b), 0);
    chk("R11 still idle", 32'(busy_b), 0);
    pd_n = 1'b1;
    tick();
    chk("R11 idle after release", 32'(st_b), 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule